// File: doc/BRIEF.md
# Programmable Watchdog Timer with Reset Steering

This block is a watchdog that is set up through one byte-wide configuration register. The low two bits choose a resolution that is a power of four, and the next five bits give a multiplier. Their product is the timeout, counted in ticks of an external 16 Hz enable. The top bit picks what expiry does. When it is set, expiry asks for a system reset, wipes the configuration register and strobes a clear to the century bit kept in a neighbouring clock block. When it is clear, expiry raises a one-cycle interrupt pulse.

Software services the watchdog by writing the register or by reading it. Either access reloads the countdown and clears the sticky watchdog flag, which stands in for the flag bit of the surrounding flags register. A value whose interval works out to zero keeps the watchdog disarmed. The tick divider and the reset controller sit outside this block.

Top module: `wdog_timer`

## Requirements
- R1: After the asynchronous reset, the stored configuration is 0x00, the flag is 0 and no pulse output is high.
- R2: The configuration fields are resolution = bits [1:0] and multiplier = bits [6:2]. The timeout is 4^resolution × multiplier tick enables, and expiry happens on the tick that completes that count.
- R3: A stored value whose multiplier is zero, including 0x00, runs no countdown and never expires.
- R4: A write stores the byte, clears the flag and restarts the countdown with the interval of the new byte.
- R5: A read clears the flag and restarts the countdown with the stored byte's interval. This also applies after an interrupt-mode expiry, which rearms the timer.
- R6: Expiry sets the flag. The flag stays set until the next write or read.
- R7: When bit 7 is set at expiry, the configuration becomes 0x00. The reset request and the century clear each pulse high for exactly one clock, and no interrupt pulse occurs.
- R8: When bit 7 is clear at expiry, the interrupt pulses high for exactly one clock, no reset request or century clear occurs, and the configuration is kept.
- R9: Asserting the reset in the middle of a countdown stops it. No expiry follows unless the timer is configured again.
- R10: Clocks without a tick enable do not advance the countdown. When a write and a read coincide, the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_en | input | 1 | One-clock enable at 16 Hz |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rd | input | 1 | Configuration read strobe (services the watchdog) |
| cfg_rdata | output | 8 | Stored configuration byte |
| wd_flag | output | 1 | Sticky watchdog-expired flag |
| sys_rst_req | output | 1 | One-clock system reset request |
| wd_irq | output | 1 | One-clock interrupt pulse |
| century_clr | output | 1 | One-clock strobe that clears the external century bit |

## Verification
On every cycle, the assertions check the following: the two expiry outcomes never occur together, every pulse lasts a single clock, the flag is set whenever a pulse is present, any access clears the flag, the configuration is empty during a reset request, and the counter stays within range and holds still when no tick arrives. The exact tick count for each resolution and multiplier pair can only be shown by the bench's scenarios, running from the smallest interval up to the largest, 1984 ticks. The same holds for rearming by a read, a zero multiplier that never expires, and a reset that cuts a countdown short.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int RES_W   = 2;
  localparam int MULT_W  = 5;
  localparam int CFG_W   = RES_W + MULT_W + 1;
  localparam int SHIFT_MAX = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W   = MULT_W + SHIFT_MAX;
  localparam int CNT_MAX = ((1 << MULT_W) - 1) << SHIFT_MAX;

  typedef struct packed {
    logic              to_reset;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_interval.sv
module wdog_interval
  import wdog_pkg::*;
(
  input  wdog_cfg_t        cfg,
  output logic [CNT_W-1:0] ticks
);
  logic [CNT_W-1:0] base;

  always_comb begin
    base  = CNT_W'(cfg.mult);
    ticks = base << {cfg.res, 1'b0};
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    expire = 1'b0;
    if (load) begin
      cnt_d = load_val;
      act_d = (load_val != '0);
    end else if (act_q && tick_en) begin
      if (cnt_q == CNT_W'(1)) begin
        expire = 1'b1;
        act_d  = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !tick_en && !load) |=> $stable(cnt_q)); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX)); // R2
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (cnt_q == '0)); // R3
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic to_reset,
  output logic rst_req,
  output logic irq,
  output logic cent_clr
);
  logic rst_d, irq_d;

  always_comb begin
    rst_d = expire && to_reset;
    irq_d = expire && !to_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      irq      <= 1'b0;
      cent_clr <= 1'b0;
    end else begin
      rst_req  <= rst_d;
      irq      <= irq_d;
      cent_clr <= rst_d;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq)); // R7
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R7
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16_en,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cfg_rd,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             wd_flag,
  output logic             sys_rst_req,
  output logic             wd_irq,
  output logic             century_clr
);
  wdog_cfg_t        cfg_q, cfg_d, cfg_src;
  logic             flag_q, flag_d;
  logic             load, expire;
  logic [CNT_W-1:0] load_ticks;

  always_comb begin
    load    = cfg_wr || cfg_rd;
    cfg_src = cfg_wr ? wdog_cfg_t'(cfg_wdata) : cfg_q;
  end

  wdog_interval u_interval (
    .cfg   (cfg_src),
    .ticks (load_ticks)
  );

  wdog_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick16_en),
    .load     (load),
    .load_val (load_ticks),
    .expire   (expire)
  );

  wdog_steer u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .to_reset (cfg_q.to_reset),
    .rst_req  (sys_rst_req),
    .irq      (wd_irq),
    .cent_clr (century_clr)
  );

  always_comb begin
    cfg_d  = cfg_q;
    flag_d = flag_q;
    if (cfg_wr) begin
      cfg_d = wdog_cfg_t'(cfg_wdata);
    end else if (expire && cfg_q.to_reset) begin
      cfg_d = '0;
    end
    if (load) begin
      flag_d = 1'b0;
    end else if (expire) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      flag_q <= flag_d;
    end
  end

  assign cfg_rdata = cfg_q;
  assign wd_flag   = flag_q;

  AST_RST_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (cfg_q == '0)); // R7
  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_req || wd_irq) |-> wd_flag); // R6
  AST_ACCESS_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || cfg_rd) |=> !wd_flag); // R4
  AST_CENT_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(century_clr) |-> $rose(sys_rst_req)); // R7
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // {config byte, ticks to expiry}
  localparam logic [23:0] VEC [NV] = '{
    {8'h05, 16'd4}, {8'h04, 16'd1}, {8'h7C, 16'd31}, {8'h8A, 16'd32},
    {8'h0D, 16'd12}, {8'h86, 16'd16}, {8'h7F, 16'd1984}, {8'hFE, 16'd496}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick16_en = 1'b0;
  logic cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic wd_flag, sys_rst_req, wd_irq, century_clr;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  wdog_timer u0 (.clk(clk), .rst_n(rst_n), .tick16_en(tick16_en), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata), .wd_flag(wd_flag),
    .sys_rst_req(sys_rst_req), .wd_irq(wd_irq), .century_clr(century_clr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {wd_flag, sys_rst_req, wd_irq, century_clr};
  endfunction

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); cfg_rd = 1'b1;
    @(negedge clk); cfg_rd = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick16_en = 1'b1;
    @(negedge clk); tick16_en = 1'b0;
  endtask

  task automatic ticks_quiet(input int n, output bit early);
    early = 1'b0;
    for (int i = 0; i < n; i++) begin
      do_tick();
      if (outs() != 0) early = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit early;
    repeat (3) @(negedge clk);
    check(cfg_rdata == 8'h00 && outs() == 0, "R1 reset state", {cfg_rdata, 4'(outs())}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: each entry expires after exactly its tick count (R2, R7, R8)
    for (int k = 0; k < NV; k++) begin
      logic [7:0] cv = VEC[k][23:16];
      int nt = int'(VEC[k][15:0]);
      do_write(cv);
      check(cfg_rdata == cv && !wd_flag, "R4 write stores and clears flag", cfg_rdata, cv);
      ticks_quiet(nt - 1, early);
      check(!early, "R2 no expiry before count", early, 0);
      do_tick();
      if (cv[7]) begin
        check(outs() == 4'b1101, "R7 reset-path pulses", outs(), 4'b1101);
        check(cfg_rdata == 8'h00, "R7 config wiped", cfg_rdata, 0);
      end else begin
        check(outs() == 4'b1010, "R8 irq-path pulse", outs(), 4'b1010);
        check(cfg_rdata == cv, "R8 config kept", cfg_rdata, cv);
      end
      @(negedge clk);
      check(outs() == 4'b1000, "R6 flag sticky, pulses single", outs(), 4'b1000);
    end

    // R5: read after irq expiry clears flag and rearms
    do_write(8'h0C);
    ticks_quiet(2, early);
    do_read();
    check(!wd_flag, "R5 read clears flag", wd_flag, 0);
    ticks_quiet(2, early);
    check(!early, "R5 read restarts countdown", early, 0);
    do_tick();
    check(wd_irq && wd_flag, "R5 expiry after service", outs(), 4'b1010);
    do_read();
    check(!wd_flag, "R5 read clears flag after expiry", wd_flag, 0);
    ticks_quiet(2, early);
    do_tick();
    check(wd_irq, "R5 read rearms after expiry", wd_irq, 1);

    // R3: zero value and zero multiplier never expire
    do_write(8'h00);
    ticks_quiet(40, early);
    check(!early, "R3 zero value disarmed", early, 0);
    do_write(8'h83);
    ticks_quiet(40, early);
    check(!early, "R3 zero multiplier disarmed", early, 0);

    // R10: idle clocks do not count; write wins over read
    do_write(8'h08);
    repeat (50) @(negedge clk);
    check(outs() == 0, "R10 idle clocks hold count", outs(), 0);
    do_tick();
    check(outs() == 0, "R10 one tick of two", outs(), 0);
    do_tick();
    check(wd_irq, "R10 second tick expires", wd_irq, 1);
    @(negedge clk); cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_wdata = 8'h04;
    @(negedge clk); cfg_wr = 1'b0; cfg_rd = 1'b0;
    check(cfg_rdata == 8'h04 && !wd_flag, "R10 write wins", cfg_rdata, 8'h04);
    do_tick();
    check(wd_irq, "R10 written interval used", wd_irq, 1);

    // R9: reset mid-countdown
    do_write(8'h90);
    ticks_quiet(3, early);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(cfg_rdata == 8'h00 && outs() == 0, "R9 reset clears", cfg_rdata, 0);
    rst_n = 1'b1;
    ticks_quiet(10, early);
    check(!early, "R9 countdown stopped", early, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule